// File: doc/BRIEF.md
# Power Supply Cabinet Phase Sequencer

This block walks a high-voltage supply through one fixed work cycle. It closes the distribution cabinet, then the soft-start cabinet, then the contactor that bypasses the soft-start resistor. It then hands the run to a separate module pulse controller through a start/done handshake. When that controller reports that the modules are off, the block opens the bypass, the soft-start cabinet and the distribution cabinet in that order. The block never advances past a switching step until that stage's auxiliary feedback shows the commanded state. A programmable cycle count bounds each of these waits.

Fault inputs and an operator emergency stop are latched into sticky flags. Only an operator clear releases them. A latched flag in any closing or running phase asserts module-off at once and diverts the block into the same opening order used by a normal cycle. A new cycle begins only from idle, with every flag clear, on a one-cycle start pulse. All pins are plain control and status levels; nothing here carries a data stream, so there is no valid/ready handshake.

Top module: `cab_phase_seq`

## Requirements
- R1: After reset all three close commands, `mod_start_o` and `mod_off_o` are 0, `flags_o` is 0 and `phase_o` is 0.
- R2: Closing runs in three steps. Phase 1 drives `dist_close_o`, phase 2 adds `soft_close_o` and phase 3 adds `byp_close_o`. Each step advances only after its feedback input reads 1 (closed). `byp_close_o` is never high unless both other close commands are high, and `soft_close_o` is never high without `dist_close_o`.
- R3: Phase 4 lasts one cycle and raises `mod_start_o` for exactly that cycle. Phase 5 waits for `mod_done_i`. A `mod_done_i` pulse in any other phase has no effect.
- R4: Opening runs in two phases. Phase 6 drops `byp_close_o` and waits for the bypass feedback to read 0, then drops `soft_close_o` and waits for the soft-start feedback to read 0. Phase 7 drops `dist_close_o` and waits for its feedback to read 0, then the block returns to phase 0 with every command low.
- R5: A step whose feedback does not match within `timeout_cfg_i` cycles of entering it sets flag bit NF+1 (sequence timeout). Feedback that matches on the count equal to `timeout_cfg_i` still passes. A timeout in a closing step aborts to phase 6; a timeout in an opening step moves on to the next opening step.
- R6: Each `fault_i[k]` is latched into `flags_o[k]` and stays set until `clear_i`. A clear while that fault input is still high leaves the flag set.
- R7: `estop_i` is latched into `flags_o[NF]` and acts exactly as a fault does.
- R8: A flag latched while the block is in phases 1 to 5 raises `mod_off_o` from the next cycle. The block then goes to phase 6 and opens the stages in the order of R4. `mod_off_o` stays high until the block is idle with no flag set.
- R9: `start_i` is accepted only in phase 0 with `flags_o` all zero; anywhere else it is ignored.
- R10: `phase_o` carries the number of the current phase: 0 idle, 1 to 7 as above, with both opening sub-steps of R4 reported as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a work cycle |
| fault_i | input | NF | External fault lines, latched |
| estop_i | input | 1 | Operator emergency stop, latched |
| clear_i | input | 1 | Operator clear of latched flags |
| timeout_cfg_i | input | TW | Feedback wait limit in cycles |
| dist_fb_i | input | 1 | Distribution cabinet feedback, 1 = closed |
| soft_fb_i | input | 1 | Soft-start cabinet feedback, 1 = closed |
| byp_fb_i | input | 1 | Bypass contactor feedback, 1 = closed |
| mod_done_i | input | 1 | Pulse controller reports modules off |
| dist_close_o | output | 1 | Close command, distribution cabinet |
| soft_close_o | output | 1 | Close command, soft-start cabinet |
| byp_close_o | output | 1 | Close command, resistor bypass |
| mod_start_o | output | 1 | One-cycle start to the pulse controller |
| mod_off_o | output | 1 | Force all modules off |
| phase_o | output | 3 | Current phase number |
| flags_o | output | NF+2 | Latched flags: faults, stop, timeout |

## Verification
The bench goes after the feedback timeout boundary. A delay equal to the limit must pass, and a delay one cycle longer must abort. An off-by-one counter would abort good hardware or let a stuck contactor through. It injects faults and stops on the first cycle of every phase, including the one-cycle phase 4. A design that let a step advance past a fresh trip, or that skipped the opening order, would show a wrong phase trace or a start pulse after abort. A stuck-closed distribution feedback checks that an opening timeout flags and still reaches idle instead of hanging. Spurious done pulses, a start while busy, and a clear under a still-asserted fault confirm that those inputs cannot advance the sequence or drop a flag early.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CL_DIST, ST_CL_SOFT, ST_CL_BYP, ST_MOD_ON,
    ST_MOD_RUN, ST_OP_BYP, ST_OP_SOFT, ST_OP_DIST
  } seq_st_e;

  function automatic logic [2:0] phase_of(seq_st_e s);
    case (s)
      ST_CL_DIST:             return 3'd1;
      ST_CL_SOFT:             return 3'd2;
      ST_CL_BYP:              return 3'd3;
      ST_MOD_ON:              return 3'd4;
      ST_MOD_RUN:             return 3'd5;
      ST_OP_BYP, ST_OP_SOFT:  return 3'd6;
      ST_OP_DIST:             return 3'd7;
      default:                return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/cps_fb_timer.sv
module cps_fb_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr_i)                cnt <= '0;
    else if (en_i && cnt < limit_i) cnt <= cnt + 1'b1;
  end

  assign expired_o = en_i && (cnt >= limit_i);

  // the count restarts on every step change
  assert_tmr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !expired_o || (limit_i == '0));
endmodule

// File: rtl/cps_flag_latch.sv
module cps_flag_latch #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_i,
  input  logic          estop_i,
  input  logic          seq_i,
  input  logic          clear_i,
  output logic [NF+1:0] flags_o,
  output logic          trip_o
);
  logic [NF+1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (clear_i ? '0 : q) | {seq_i, estop_i, fault_i};
  end

  assign flags_o = q;
  assign trip_o  = |q;

  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_i) |=> (|flags_o[NF-1:0]));
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[NF] && !clear_i) |=> flags_o[NF]);
endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm
  import cps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    trip_i,
  input  logic    mod_done_i,
  input  logic    dist_fb_i,
  input  logic    soft_fb_i,
  input  logic    byp_fb_i,
  input  logic    expired_i,
  output seq_st_e st_o,
  output logic    wait_en_o,
  output logic    tmr_clr_o,
  output logic    tmo_o,
  output logic    abort_o
);
  seq_st_e st, nxt;
  logic    fb_ok, abort_q;

  always_comb begin
    case (st)
      ST_CL_DIST: fb_ok = dist_fb_i;
      ST_CL_SOFT: fb_ok = soft_fb_i;
      ST_CL_BYP:  fb_ok = byp_fb_i;
      ST_OP_BYP:  fb_ok = !byp_fb_i;
      ST_OP_SOFT: fb_ok = !soft_fb_i;
      ST_OP_DIST: fb_ok = !dist_fb_i;
      default:    fb_ok = 1'b1;
    endcase
  end

  assign wait_en_o = (st inside {ST_CL_DIST, ST_CL_SOFT, ST_CL_BYP,
                                 ST_OP_BYP, ST_OP_SOFT, ST_OP_DIST});

  always_comb begin
    nxt   = st;
    tmo_o = 1'b0;
    case (st)
      ST_IDLE:    if (start_i && !trip_i) nxt = ST_CL_DIST;
      ST_CL_DIST, ST_CL_SOFT, ST_CL_BYP: begin
        if (trip_i)         nxt = ST_OP_BYP;
        else if (fb_ok)     nxt = seq_st_e'(st + 4'd1);
        else if (expired_i) begin nxt = ST_OP_BYP; tmo_o = 1'b1; end
      end
      ST_MOD_ON:  nxt = trip_i ? ST_OP_BYP : ST_MOD_RUN;
      ST_MOD_RUN: if (trip_i || mod_done_i) nxt = ST_OP_BYP;
      ST_OP_BYP, ST_OP_SOFT: begin
        if (fb_ok)          nxt = seq_st_e'(st + 4'd1);
        else if (expired_i) begin nxt = seq_st_e'(st + 4'd1); tmo_o = 1'b1; end
      end
      ST_OP_DIST: begin
        if (fb_ok)          nxt = ST_IDLE;
        else if (expired_i) begin nxt = ST_IDLE; tmo_o = 1'b1; end
      end
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      st      <= nxt;
      abort_q <= (nxt == ST_IDLE) ? 1'b0 : (abort_q | trip_i | tmo_o);
    end
  end

  assign st_o      = st;
  assign tmr_clr_o = (nxt != st);
  assign abort_o   = abort_q | trip_i;

  assert_trip_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i && st inside {ST_CL_DIST, ST_CL_SOFT, ST_CL_BYP, ST_MOD_ON, ST_MOD_RUN})
      |=> (st == ST_OP_BYP));
  assert_start_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && trip_i) |=> (st == ST_IDLE));
  assert_hold_dist_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CL_DIST && !dist_fb_i && !expired_i && !trip_i) |=> (st == ST_CL_DIST));
  assert_done_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CL_SOFT && mod_done_i && !soft_fb_i && !expired_i && !trip_i)
      |=> (st == ST_CL_SOFT));
endmodule

// File: rtl/cab_phase_seq.sv
module cab_phase_seq
  import cps_pkg::*;
#(
  parameter int NF = 2,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NF-1:0] fault_i,
  input  logic          estop_i,
  input  logic          clear_i,
  input  logic [TW-1:0] timeout_cfg_i,
  input  logic          dist_fb_i,
  input  logic          soft_fb_i,
  input  logic          byp_fb_i,
  input  logic          mod_done_i,
  output logic          dist_close_o,
  output logic          soft_close_o,
  output logic          byp_close_o,
  output logic          mod_start_o,
  output logic          mod_off_o,
  output logic [2:0]    phase_o,
  output logic [NF+1:0] flags_o
);
  seq_st_e st;
  logic    wait_en, tmr_clr, expired, tmo, trip;

  cps_flag_latch #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .estop_i(estop_i),
    .seq_i(tmo), .clear_i(clear_i), .flags_o(flags_o), .trip_o(trip)
  );

  cps_fb_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .en_i(wait_en),
    .limit_i(timeout_cfg_i), .expired_o(expired)
  );

  cps_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trip_i(trip),
    .mod_done_i(mod_done_i), .dist_fb_i(dist_fb_i), .soft_fb_i(soft_fb_i),
    .byp_fb_i(byp_fb_i), .expired_i(expired), .st_o(st), .wait_en_o(wait_en),
    .tmr_clr_o(tmr_clr), .tmo_o(tmo), .abort_o(mod_off_o)
  );

  assign dist_close_o = (st >= ST_CL_DIST) && (st <= ST_OP_SOFT);
  assign soft_close_o = (st >= ST_CL_SOFT) && (st <= ST_OP_BYP);
  assign byp_close_o  = (st >= ST_CL_BYP)  && (st <= ST_MOD_RUN);
  assign mod_start_o  = (st == ST_MOD_ON);
  assign phase_o      = phase_of(st);

  assert_interlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byp_close_o |-> (soft_close_o && dist_close_o));
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start_o |=> !mod_start_o);
  assert_start_after_byp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_start_o) |-> $past(byp_fb_i));
endmodule

// File: tb/sim_cab_phase_seq.sv
module sim_cab_phase_seq;
  localparam int NF = 2;
  localparam int TW = 16;
  localparam int TMO = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, estop_i = 0, clear_i = 0, spur_done = 0;
  logic [NF-1:0] fault_i = '0;
  logic [TW-1:0] timeout_cfg_i = TW'(TMO);
  logic dist_close_o, soft_close_o, byp_close_o, mod_start_o, mod_off_o;
  logic [2:0] phase_o;
  logic [NF+1:0] flags_o;
  logic [2:0] fb;
  logic done_m;

  int checks = 0, errors = 0;
  int dly [3];
  bit stuck [3];
  int pc [3];
  int run_len = 4, rc = 0;
  int tr [16];
  int tn = 0, last_ph = 0, ilk_bad = 0, msc = 0, ms_wide = 0;
  logic prev_ms = 0;
  int exp_tr [16];
  int exp_n = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cab_phase_seq #(.NF(NF), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fault_i(fault_i),
    .estop_i(estop_i), .clear_i(clear_i), .timeout_cfg_i(timeout_cfg_i),
    .dist_fb_i(fb[0]), .soft_fb_i(fb[1]), .byp_fb_i(fb[2]),
    .mod_done_i(done_m | spur_done), .dist_close_o(dist_close_o),
    .soft_close_o(soft_close_o), .byp_close_o(byp_close_o),
    .mod_start_o(mod_start_o), .mod_off_o(mod_off_o), .phase_o(phase_o),
    .flags_o(flags_o)
  );

  // switchgear model: feedback follows its command after dly cycles
  wire [2:0] cmd = {byp_close_o, soft_close_o, dist_close_o};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb <= '0;
      for (int k = 0; k < 3; k++) pc[k] <= 0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (!stuck[k]) begin
          if (cmd[k] != fb[k]) begin
            if (pc[k] >= dly[k] - 1) begin fb[k] <= cmd[k]; pc[k] <= 0; end
            else pc[k] <= pc[k] + 1;
          end else pc[k] <= 0;
        end
      end
    end
  end

  // pulse controller model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rc <= 0; done_m <= 0; end
    else begin
      done_m <= 0;
      if (mod_start_o) rc <= run_len;
      else if (mod_off_o) rc <= 0;
      else if (rc != 0) begin
        rc <= rc - 1;
        if (rc == 1) done_m <= 1;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(phase_o) != last_ph) begin
        if (tn < 16) tr[tn] = int'(phase_o);
        tn++;
        last_ph = int'(phase_o);
      end
      if (byp_close_o && !(soft_close_o && dist_close_o)) ilk_bad++;
      if (soft_close_o && !dist_close_o) ilk_bad++;
      if (mod_start_o && !prev_ms) msc++;
      if (mod_start_o && prev_ms) ms_wide++;
      prev_ms = mod_start_o;
    end
  end

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic trace_reset();
    @(posedge clk); #1;
    tn = 1; tr[0] = int'(phase_o); last_ph = int'(phase_o);
    ilk_bad = 0; msc = 0; ms_wide = 0;
  endtask

  // expected phase trace when closing/running stops at phase p (p=5 is normal)
  function automatic void build_exp(int p);
    exp_n = 0;
    for (int i = 0; i <= p; i++) begin exp_tr[exp_n] = i; exp_n++; end
    exp_tr[exp_n] = 6; exp_tr[exp_n+1] = 7; exp_tr[exp_n+2] = 0;
    exp_n += 3;
  endfunction

  task automatic cmp_trace(string req);
    int bad = 0;
    chk({req, " trace length"}, tn, exp_n);
    for (int i = 0; i < exp_n && i < 16; i++)
      if (bad == 0 && tr[i] != exp_tr[i]) begin
        bad = 1;
        chk({req, " trace entry"}, tr[i], exp_tr[i]);
      end
    if (bad == 0) checks++;
  endtask

  task automatic wait_ph(int p, string req);
    int n = 0;
    while (int'(phase_o) != p && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk({req, " wait phase"}, int'(phase_o), p);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic do_clear();
    @(negedge clk) clear_i = 1;
    @(negedge clk) clear_i = 0;
  endtask

  // kind: 0 none, 1 fault line, 2 emergency stop
  task automatic run_cycle(int p, int kind, int line, string req);
    int ef;
    trace_reset();
    pulse_start();
    if (kind != 0) begin
      wait_ph(p, req);
      if (kind == 1) fault_i[line] = 1'b1; else estop_i = 1'b1;
      @(negedge clk);
      fault_i = '0; estop_i = 0;
      ef = (kind == 1) ? (1 << line) : (1 << NF);
      chk({req, " R8 mod_off after trip"}, int'(mod_off_o), 1);
      chk({req, " R6/R7 flag latched"}, int'(flags_o), ef);
    end
    wait_ph(0, req);
    @(negedge clk);
    build_exp((kind == 0) ? 5 : ((p == 4) ? 5 : p));
    cmp_trace({req, " R10 phase order"});
    chk({req, " R2 interlock"}, ilk_bad, 0);
    chk({req, " R3 start count"}, msc, (kind == 0 || p >= 4) ? 1 : 0);
    chk({req, " R3 start width"}, ms_wide, 0);
    chk({req, " R4 commands idle"}, int'(cmd), 0);
    if (kind != 0) begin
      pulse_start();
      repeat (4) @(negedge clk);
      chk({req, " R9 start blocked"}, int'(phase_o), 0);
      do_clear();
      chk({req, " R6 cleared"}, int'(flags_o), 0);
      chk({req, " R8 mod_off released"}, int'(mod_off_o), 0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4321));
    for (int k = 0; k < 3; k++) begin dly[k] = 3; stuck[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 commands", int'(cmd), 0);
    chk("R1 mod_start", int'(mod_start_o), 0);
    chk("R1 mod_off", int'(mod_off_o), 0);
    chk("R1 flags", int'(flags_o), 0);
    chk("R1 phase", int'(phase_o), 0);

    // R2 R4 normal cycle
    run_cycle(0, 0, 0, "normal");

    // R3 spurious done while closing, R9 start while running
    dly[1] = 5; run_len = 30;
    trace_reset();
    pulse_start();
    wait_ph(2, "R3 spur");
    spur_done = 1;
    @(negedge clk) spur_done = 0;
    chk("R3 done ignored in phase 2", int'(phase_o), 2);
    wait_ph(5, "R9 busy");
    pulse_start();
    wait_ph(0, "R9 busy");
    @(negedge clk);
    build_exp(5);
    cmp_trace("R9 start while busy R10");
    chk("R3 single start", msc, 1);
    chk("R2 closing holds bypass off", ilk_bad, 0);
    run_len = 4;

    // R5 boundary: delay equal to limit passes
    dly[1] = TMO;
    run_cycle(0, 0, 0, "R5 at limit");
    chk("R5 no flag at limit", int'(flags_o), 0);
    // one cycle more times out in closing
    dly[1] = TMO + 1;
    trace_reset();
    pulse_start();
    wait_ph(0, "R5 over");
    @(negedge clk);
    build_exp(2);
    cmp_trace("R5 over limit abort");
    chk("R5 timeout flag", int'(flags_o), 1 << (NF + 1));
    repeat (TMO + 4) @(negedge clk);
    do_clear();
    chk("R5 flag cleared", int'(flags_o), 0);
    dly[1] = 3;

    // R5 opening timeout: distribution feedback stuck closed
    trace_reset();
    pulse_start();
    wait_ph(6, "R5 open");
    stuck[0] = 1;
    wait_ph(0, "R5 open");
    @(negedge clk);
    build_exp(5);
    cmp_trace("R5 opening timeout reaches idle");
    chk("R5 opening flag", int'(flags_o), 1 << (NF + 1));
    stuck[0] = 0;
    repeat (8) @(negedge clk);
    chk("R4 feedback settled", int'(fb), 0);
    do_clear();

    // R6 clear under held fault
    @(negedge clk) fault_i[1] = 1'b1;
    do_clear();
    chk("R6 clear while held", int'(flags_o), 2);
    chk("R8 mod_off with flag in idle", int'(mod_off_o), 1);
    @(negedge clk) fault_i = '0;
    do_clear();
    chk("R6 clear after release", int'(flags_o), 0);

    // R7 R8 directed stop and fault in each phase
    for (int p = 1; p <= 5; p++) run_cycle(p, 2, 0, "R7 stop");
    for (int p = 1; p <= 5; p++) run_cycle(p, 1, p % NF, "R8 fault");

    // random mix
    for (int it = 0; it < 24; it++) begin
      for (int k = 0; k < 3; k++) dly[k] = int'($urandom_range(TMO, 1));
      run_len = int'($urandom_range(20, 2));
      run_cycle(int'($urandom_range(5, 1)), int'($urandom_range(2, 0)),
                int'($urandom_range(NF - 1, 0)), "random");
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule